// File: doc/BRIEF.md
# Cache Tag Store with Hit Comparator

This block is the tag memory of a direct-indexed secondary cache. Each entry holds a tag and three status bits: valid, dirty and write-through. A set index picks one entry. The block compares that entry's stored tag with the tag offered on the input and raises a hit flag. From the hit and the status bits it also produces an active-low burst-ready strobe, which a cache controller can use directly to start a data transfer.

Lookups and reads are combinational from the index and probe inputs. Tag and status writes take effect on the rising clock edge, each under its own enable. A controller can therefore, for example, set the dirty bit on a write hit without rewriting the tag. A single clocked reset clears the status of every entry in one cycle; this is how the whole cache is invalidated.

A mode input picks how the status bits are used. In built-in mode the block reads valid and write-through itself. In generic mode the three bits are plain storage, and the block neither checks nor acts on them.

Top module: `tag_store_top`

## Requirements
- R1: On a rising edge with `tag_we_i` high, `tag_i` is stored at entry `idx_i`. On a rising edge with `stat_we_i` high, `stat_i` is stored at that entry. `tag_o` and `stat_o` always show the entry currently addressed by `idx_i`, combinationally. Status bit positions: [2] valid, [1] dirty, [0] write-through.
- R2: The two enables act independently. A status-only write leaves the stored tag unchanged, and a tag-only write leaves the stored status unchanged.
- R3: With `gen_mode_i` low, `hit_o` is high only when the addressed entry's valid bit is set and its stored tag equals `tag_i`.
- R4: With `gen_mode_i` high, `hit_o` is high exactly when the stored tag equals `tag_i`, whatever the valid bit is.
- R5: When `rst_ni` is low at a rising edge, the status bits of every entry are zero after that one edge. Stored tags are kept.
- R6: When reset and a status write happen in the same cycle, reset wins and the addressed status reads zero. A tag write in that cycle still completes.
- R7: With `rd_cyc_i` high (read cycle) and `brdy_en_i` high, `brdy_no` is low exactly when `hit_o` is high.
- R8: With `rd_cyc_i` low (write cycle), `gen_mode_i` low and `brdy_en_i` high, `brdy_no` is low exactly when `hit_o` is high and the write-through bit is clear. A write hit on a write-through entry keeps `brdy_no` high.
- R9: With `gen_mode_i` high, the status bits have no effect on `brdy_no`. A write-cycle hit drives it low even when the write-through bit is set.
- R10: With `brdy_en_i` low, `brdy_no` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes and reset act on its rising edge |
| rst_ni | input | 1 | Active-low, edge-sampled clear of all status bits |
| idx_i | input | IDX_W | Set index |
| tag_i | input | TAG_W | Probe tag and tag write data |
| tag_we_i | input | 1 | Tag write enable |
| stat_we_i | input | 1 | Status write enable |
| stat_i | input | 3 | Status write data {valid, dirty, write-through} |
| gen_mode_i | input | 1 | 1: status bits are generic storage |
| rd_cyc_i | input | 1 | 1: read cycle, 0: write cycle |
| brdy_en_i | input | 1 | Burst-ready enable |
| tag_o | output | TAG_W | Stored tag at `idx_i` |
| stat_o | output | 3 | Stored status at `idx_i` |
| hit_o | output | 1 | Tag hit |
| brdy_no | output | 1 | Burst ready, active low |

## Verification
Every entry is filled with a distinct tag and a mix of status values. Each entry is then probed with its own tag and with tags that differ in the lowest bit and in the highest bit. This separates true equality from a partial compare. Each probe is repeated across all combinations of mode, cycle type and enable, so that valid gating, write-through blocking, generic-mode bypass and enable gating each show up as a separate mismatch. Independent-enable writes, and a reset that coincides with a write, show whether the tag and status fields are stored separately and whether the clear wins over the status write.

// File: rtl/tag_store_pkg.sv
package tag_store_pkg;
  typedef struct packed {
    logic valid;
    logic dirty;
    logic wt;
  } stat_t;
  localparam int STAT_W = $bits(stat_t);
endpackage

// File: rtl/tag_array.sv
module tag_array
  import tag_store_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TAG_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             tag_we_i,
  input  logic [TAG_W-1:0] tag_wd_i,
  input  logic             stat_we_i,
  input  stat_t            stat_wd_i,
  output logic [TAG_W-1:0] tag_rd_o,
  output stat_t            stat_rd_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [DEPTH];
  stat_t            stat_q  [DEPTH];

  // tags carry no reset: only status is invalidated
  always_ff @(posedge clk_i) begin
    if (tag_we_i) tag_mem[idx_i] <= tag_wd_i;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_stat
    always_ff @(posedge clk_i) begin
      if (!rst_ni)                                stat_q[e] <= '0;
      else if (stat_we_i && idx_i == IDX_W'(e))   stat_q[e] <= stat_wd_i;
    end
  end

  assign tag_rd_o  = tag_mem[idx_i];
  assign stat_rd_o = stat_q[idx_i];
endmodule

// File: rtl/tag_cmp.sv
module tag_cmp #(
  parameter int TAG_W = 12
) (
  input  logic [TAG_W-1:0] stored_i,
  input  logic [TAG_W-1:0] probe_i,
  input  logic             valid_i,
  input  logic             gen_mode_i,
  output logic             hit_o
);
  logic eq;
  assign eq    = (stored_i == probe_i);
  assign hit_o = eq && (gen_mode_i || valid_i);
endmodule

// File: rtl/brdy_gen.sv
module brdy_gen (
  input  logic hit_i,
  input  logic wt_i,
  input  logic gen_mode_i,
  input  logic rd_cyc_i,
  input  logic en_i,
  output logic brdy_no
);
  logic wt_blk;
  // write-through only blocks write cycles, and only in built-in mode
  assign wt_blk  = !gen_mode_i && !rd_cyc_i && wt_i;
  assign brdy_no = !(en_i && hit_i && !wt_blk);
endmodule

// File: rtl/tag_store_top.sv
module tag_store_top
  import tag_store_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TAG_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             tag_we_i,
  input  logic             stat_we_i,
  input  logic [2:0]       stat_i,
  input  logic             gen_mode_i,
  input  logic             rd_cyc_i,
  input  logic             brdy_en_i,
  output logic [TAG_W-1:0] tag_o,
  output logic [2:0]       stat_o,
  output logic             hit_o,
  output logic             brdy_no
);
  stat_t stat_rd;
  stat_t stat_wd;
  logic  hit;

  assign stat_wd = stat_t'(stat_i);

  tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_i     (idx_i),
    .tag_we_i  (tag_we_i),
    .tag_wd_i  (tag_i),
    .stat_we_i (stat_we_i),
    .stat_wd_i (stat_wd),
    .tag_rd_o  (tag_o),
    .stat_rd_o (stat_rd)
  );

  tag_cmp #(.TAG_W(TAG_W)) u_cmp (
    .stored_i   (tag_o),
    .probe_i    (tag_i),
    .valid_i    (stat_rd.valid),
    .gen_mode_i (gen_mode_i),
    .hit_o      (hit)
  );

  brdy_gen u_brdy (
    .hit_i      (hit),
    .wt_i       (stat_rd.wt),
    .gen_mode_i (gen_mode_i),
    .rd_cyc_i   (rd_cyc_i),
    .en_i       (brdy_en_i),
    .brdy_no    (brdy_no)
  );

  assign hit_o  = hit;
  assign stat_o = stat_rd;
endmodule

// File: rtl/tag_store_chk.sv
module tag_store_chk #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IDX_W-1:0] idx_i,
  input logic [TAG_W-1:0] tag_i,
  input logic             tag_we_i,
  input logic             gen_mode_i,
  input logic             rd_cyc_i,
  input logic             brdy_en_i,
  input logic [TAG_W-1:0] tag_o,
  input logic [2:0]       stat_o,
  input logic             hit_o,
  input logic             brdy_no
);
  // R1
  tag_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we_i |=> (idx_i != $past(idx_i)) || (tag_o == $past(tag_i)));

  // R3
  hit_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !gen_mode_i) |-> stat_o[2]);

  // R3
  hit_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (tag_o == tag_i));

  // R5
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (stat_o == 3'b000));

  // R8
  wt_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gen_mode_i && !rd_cyc_i && stat_o[0]) |-> brdy_no);

  // R10
  brdy_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brdy_no |-> (hit_o && brdy_en_i));
endmodule

bind tag_store_top tag_store_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .idx_i      (idx_i),
  .tag_i      (tag_i),
  .tag_we_i   (tag_we_i),
  .gen_mode_i (gen_mode_i),
  .rd_cyc_i   (rd_cyc_i),
  .brdy_en_i  (brdy_en_i),
  .tag_o      (tag_o),
  .stat_o     (stat_o),
  .hit_o      (hit_o),
  .brdy_no    (brdy_no)
);

// File: tb/tag_store_top_tb_top.sv
module tag_store_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 4;
  localparam int TAG_W = 12;
  localparam int DEPTH = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             tag_we, stat_we, gen_mode, rd_cyc, brdy_en;
  logic [2:0]       stat;
  logic [TAG_W-1:0] tag_o;
  logic [2:0]       stat_o;
  logic             hit_o, brdy_no;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [TAG_W-1:0] m_tag  [DEPTH];
  logic [2:0]       m_stat [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_store_top #(.IDX_W(IDX_W), .TAG_W(TAG_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .idx_i(idx), .tag_i(tag),
    .tag_we_i(tag_we), .stat_we_i(stat_we), .stat_i(stat),
    .gen_mode_i(gen_mode), .rd_cyc_i(rd_cyc), .brdy_en_i(brdy_en),
    .tag_o(tag_o), .stat_o(stat_o), .hit_o(hit_o), .brdy_no(brdy_no)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic [TAG_W-1:0] t, input logic [2:0] s,
                    input logic twe, input logic swe);
    @(negedge clk);
    idx = IDX_W'(i); tag = t; stat = s; tag_we = twe; stat_we = swe;
    @(negedge clk);
    tag_we = 1'b0; stat_we = 1'b0;
    if (twe) m_tag[i] = t;
    if (swe) m_stat[i] = s;
  endtask

  task automatic look(input int i, input logic [TAG_W-1:0] p,
                      input logic gm, input logic rd, input logic en);
    logic eh, eb;
    @(negedge clk);
    idx = IDX_W'(i); tag = p; gen_mode = gm; rd_cyc = rd; brdy_en = en;
    #1;
    eh = (m_tag[i] == p) && (gm || m_stat[i][2]);
    eb = !(en && eh && (rd || gm || !m_stat[i][0]));
    chk(hit_o == eh, gm ? "R4 hit" : "R3 hit", 32'(hit_o), 32'(eh));
    if (!en)     chk(brdy_no == eb, "R10 brdy", 32'(brdy_no), 32'(eb));
    else if (rd) chk(brdy_no == eb, "R7 brdy", 32'(brdy_no), 32'(eb));
    else if (gm) chk(brdy_no == eb, "R9 brdy", 32'(brdy_no), 32'(eb));
    else         chk(brdy_no == eb, "R8 brdy", 32'(brdy_no), 32'(eb));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; idx = '0; tag = '0; tag_we = 1'b0; stat_we = 1'b0; stat = '0;
    gen_mode = 1'b0; rd_cyc = 1'b1; brdy_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R5: reset state
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); idx = IDX_W'(i); #1;
      chk(stat_o == 3'b000, "R5 reset status", 32'(stat_o), 0);
      m_stat[i] = 3'b000;
    end

    // R1: fill every entry
    for (int i = 0; i < DEPTH; i++) begin
      logic [2:0] s;
      s = {(i % 2 == 0) || (i % 5 == 1), (i % 4 == 1), (i % 3 == 0)};
      wr(i, TAG_W'(i * 37 + 5), s, 1'b1, 1'b1);
    end
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); idx = IDX_W'(i); #1;
      chk(tag_o == m_tag[i], "R1 tag read", 32'(tag_o), 32'(m_tag[i]));
      chk(stat_o == m_stat[i], "R1 status read", 32'(stat_o), 32'(m_stat[i]));
    end

    // R3 R4 R7 R8 R9 R10: lookup sweep
    for (int i = 0; i < DEPTH; i++) begin
      for (int p = 0; p < 3; p++) begin
        for (int c = 0; c < 8; c++) begin
          logic [TAG_W-1:0] pt;
          pt = (p == 0) ? m_tag[i] : (p == 1) ? (m_tag[i] ^ TAG_W'(1)) : (m_tag[i] ^ (TAG_W'(1) << (TAG_W-1)));
          look(i, pt, c[2], c[1], c[0]);
        end
      end
    end

    // R2: status-only then tag-only write
    wr(5, 12'h000, 3'b010, 1'b0, 1'b1);
    @(negedge clk); idx = 5; #1;
    chk(tag_o == m_tag[5], "R2 tag kept", 32'(tag_o), 32'(m_tag[5]));
    chk(stat_o == 3'b010, "R2 status set", 32'(stat_o), 32'h2);
    wr(6, 12'habc, 3'b111, 1'b1, 1'b0);
    @(negedge clk); idx = 6; #1;
    chk(tag_o == 12'habc, "R2 tag set", 32'(tag_o), 32'habc);
    chk(stat_o == m_stat[6], "R2 status kept", 32'(stat_o), 32'(m_stat[6]));

    // R5 R6: one-cycle reset coinciding with a write
    @(negedge clk);
    rst_ni = 1'b0; idx = 3; tag = 12'h5a5; stat = 3'b111; tag_we = 1'b1; stat_we = 1'b1;
    @(negedge clk);
    rst_ni = 1'b1; tag_we = 1'b0; stat_we = 1'b0;
    m_tag[3] = 12'h5a5;
    for (int i = 0; i < DEPTH; i++) m_stat[i] = 3'b000;
    @(negedge clk); idx = 3; #1;
    chk(tag_o == 12'h5a5, "R6 tag write completes", 32'(tag_o), 32'h5a5);
    chk(stat_o == 3'b000, "R6 reset beats status write", 32'(stat_o), 0);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); idx = IDX_W'(i); #1;
      chk(stat_o == 3'b000, "R5 all status cleared", 32'(stat_o), 0);
      chk(tag_o == m_tag[i], "R5 tag retained", 32'(tag_o), 32'(m_tag[i]));
    end
    for (int i = 0; i < DEPTH; i++) begin
      look(i, m_tag[i], 1'b0, 1'b1, 1'b1);
      look(i, m_tag[i], 1'b1, 1'b0, 1'b1);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule